// File: doc/BRIEF.md
# Monte Carlo Arithmetic-Average Option Pricer

This block estimates the value of an option whose payoff depends on the arithmetic mean of the asset price along a path. A host writes the starting price, the strike, a drift increment, a volatility increment, the step and path counts, two reciprocals and twelve generator seeds into a small write-only register file. It then pulses `start`. The engine simulates every path one time step per clock. Each step draws a fresh approximately Gaussian number, applies a multiplicative price update and adds the new price to a running sum.

At the end of each path the running sum becomes an average price. The engine evaluates the call and put payoffs against the strike in the same pass and adds the average and both payoffs to path accumulators. After the last path it scales the three accumulators by the path reciprocal, presents the means and pulses `done`. All arithmetic is fixed point. Prices, strike and increments are signed Q16.16, and the reciprocals are unsigned Q0.32, so no divider is needed.

Top module: `mc_asian_engine`

## Requirements
- R1: Register writes (`cfgWe`, `cfgAddr`, `cfgData`) take effect only while `busy` is low; a write while busy is dropped. The address map is: 0 start price, 1 strike, 2 drift increment, 3 volatility increment, 4 step count N, 5 path count P, 6 step reciprocal, 7 path reciprocal, 8..19 seeds of generator lanes 0..11 (low 16 bits).
- R2: After reset `busy`, `done`, `meanAvg`, `meanCall` and `meanPut` are all zero.
- R3: The Gaussian number is the sum of twelve 16-bit lane states, read as Q0.16 fractions, minus 6.0. Each lane is a left-shifting 16-bit LFSR whose new bit 0 is the XOR of state bits 15, 13, 12 and 10. All lanes reload from their seeds on an accepted start, and a zero seed is replaced by 1. Every step uses the current lane states and then advances every lane once, so a run consumes exactly N×P draws.
- R4: One step computes factor = 1.0 + drift + ((vol × eps) >>> 16). The new price is (price × factor) >>> 16, clamped to the range 0 to 0x7FFFFFFF.
- R5: Every path starts from the start price (a negative value is taken as 0). The path average is (sum of its N step prices × step reciprocal) >> 32, clamped to 0x7FFFFFFF.
- R6: The call payoff is max(avg − strike, 0) and the put payoff is max(strike − avg, 0). An average equal to the strike gives zero for both.
- R7: The average, call and put values are summed over paths in 64-bit accumulators that saturate. Each output is (sum × path reciprocal) >> 32, clamped to 0x7FFFFFFF.
- R8: With N and P nonzero, `busy` rises on the edge that samples `start`. `done` is high for exactly one cycle, beginning P·(N+1)+1 edges after that edge.
- R9: A `start` pulse while `busy` is high has no effect on the run in progress, on its timing or on its results.
- R10: If N or P is zero, a start completes with `done` one cycle later (0 further edges) and all three outputs become zero.
- R11: The outputs hold their values between completions.
- R12: Two runs with the same registers give identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 5 | Register address |
| cfgData | input | 32 | Register write data |
| start | input | 1 | Begin a pricing run (one-cycle pulse) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| meanAvg | output | 32 | Mean path average price, Q16.16 |
| meanCall | output | 32 | Mean call payoff, Q16.16 |
| meanPut | output | 32 | Mean put payoff, Q16.16 |

## Verification
The lanes are never reset between steps, so any lost or extra advance of the generator shifts every later draw. That error appears in all three means when `done` rises. An off-by-one in the step or path counters shows up in two places: as a `done` pulse one or more cycles off the P·(N+1)+1 schedule, and as a changed average, because the average is scaled by a fixed reciprocal. Setting the volatility increment to zero isolates the compounding, averaging and payoff arithmetic, so a rounding or clamp fault can be told apart from a generator fault. Runs repeated with equal, zero and altered seeds expose state that leaks from one run into the next.

// File: rtl/mca_pkg.sv
package mca_pkg;
  localparam int DATA_W    = 32;
  localparam int FRAC_W    = 16;
  localparam int ACC_W     = 64;
  localparam int FACT_W    = 48;
  localparam int LANES     = 12;
  localparam int LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam int ADDR_W    = 5;
  localparam int SEED_BASE = 8;

  localparam logic [ADDR_W-1:0] A_SPOT  = 5'd0;
  localparam logic [ADDR_W-1:0] A_STRK  = 5'd1;
  localparam logic [ADDR_W-1:0] A_DRIFT = 5'd2;
  localparam logic [ADDR_W-1:0] A_VOL   = 5'd3;
  localparam logic [ADDR_W-1:0] A_NSTEP = 5'd4;
  localparam logic [ADDR_W-1:0] A_NPATH = 5'd5;
  localparam logic [ADDR_W-1:0] A_INVS  = 5'd6;
  localparam logic [ADDR_W-1:0] A_INVP  = 5'd7;

  localparam logic [DATA_W-1:0] MAX_VAL = {1'b0, {(DATA_W-1){1'b1}}};

  typedef struct packed {
    logic [DATA_W-1:0] spot;
    logic [DATA_W-1:0] strike;
    logic [DATA_W-1:0] drift;
    logic [DATA_W-1:0] vol;
    logic [DATA_W-1:0] nSteps;
    logic [DATA_W-1:0] nPaths;
    logic [DATA_W-1:0] invSteps;
    logic [DATA_W-1:0] invPaths;
    logic [LANES-1:0][LFSR_W-1:0] seeds;
  } cfg_t;

  typedef struct packed {
    logic load;
    logic step;
    logic pathEnd;
    logic finish;
    logic zeroOut;
  } dp_ctl_t;

  typedef enum logic [2:0] {ST_IDLE, ST_STEP, ST_PATH, ST_FINAL, ST_DONE} state_t;
endpackage

// File: rtl/mca_cfg.sv
module mca_cfg
  import mca_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              busy,
  output cfg_t              cfgQ
);
  cfg_t regs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
      for (int i = 0; i < LANES; i++) regs.seeds[i] <= LFSR_W'(i + 1);
    end else if (cfgWe && !busy) begin
      case (cfgAddr)
        A_SPOT:  regs.spot     <= cfgData;
        A_STRK:  regs.strike   <= cfgData;
        A_DRIFT: regs.drift    <= cfgData;
        A_VOL:   regs.vol      <= cfgData;
        A_NSTEP: regs.nSteps   <= cfgData;
        A_NPATH: regs.nPaths   <= cfgData;
        A_INVS:  regs.invSteps <= cfgData;
        A_INVP:  regs.invPaths <= cfgData;
        default: begin
          for (int i = 0; i < LANES; i++)
            if (cfgAddr == ADDR_W'(SEED_BASE + i)) regs.seeds[i] <= cfgData[LFSR_W-1:0];
        end
      endcase
    end
  end

  assign cfgQ = regs;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN) busy |=> $stable(regs)); // R1
endmodule

// File: rtl/mca_gauss.sv
module mca_gauss
  import mca_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reload,
  input  logic                         advance,
  input  logic [LANES-1:0][LFSR_W-1:0] seeds,
  output logic signed [DATA_W-1:0]     eps
);
  localparam logic [DATA_W-1:0] CENTER = DATA_W'((LANES / 2) * (1 << FRAC_W));

  logic [LANES-1:0][LFSR_W-1:0] lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LFSR_W-1:0] st;
    logic [LFSR_W-1:0] seedFix;
    logic              fb;
    assign seedFix = (seeds[g] == '0) ? LFSR_W'(1) : seeds[g];
    assign fb      = ^(st & LFSR_TAPS);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        st <= LFSR_W'(g + 1);
      else if (reload)  st <= seedFix;
      else if (advance) st <= {st[LFSR_W-2:0], fb};
    end
    assign lane[g] = st;

    AST_LANE_NONZERO: assert property (@(posedge clk) disable iff (!rstN) st != '0); // R3
  end

  always_comb begin
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) acc = acc + DATA_W'(lane[i]);
    eps = $signed(acc - CENTER);
  end
endmodule

// File: rtl/mca_ctrl.sv
module mca_ctrl
  import mca_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] nSteps,
  input  logic [DATA_W-1:0] nPaths,
  output dp_ctl_t           ctl,
  output logic              busy,
  output logic              done
);
  state_t            state, stateNext;
  logic [DATA_W-1:0] stepCnt, pathCnt;
  logic              lastStep, lastPath, emptyRun;

  assign lastStep = (stepCnt == nSteps - DATA_W'(1));
  assign lastPath = (pathCnt == nPaths - DATA_W'(1));
  assign emptyRun = (nSteps == '0) || (nPaths == '0);

  always_comb begin
    stateNext = state;
    ctl       = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (emptyRun) begin
            ctl.zeroOut = 1'b1;
            stateNext   = ST_DONE;
          end else begin
            ctl.load  = 1'b1;
            stateNext = ST_STEP;
          end
        end
      end
      ST_STEP: begin
        ctl.step = 1'b1;
        if (lastStep) stateNext = ST_PATH;
      end
      ST_PATH: begin
        ctl.pathEnd = 1'b1;
        stateNext   = lastPath ? ST_FINAL : ST_STEP;
      end
      ST_FINAL: begin
        ctl.finish = 1'b1;
        stateNext  = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      pathCnt <= '0;
    end else begin
      state <= stateNext;
      if (ctl.load) begin
        stepCnt <= '0;
        pathCnt <= '0;
      end else begin
        if (ctl.step)    stepCnt <= lastStep ? '0 : stepCnt + DATA_W'(1);
        if (ctl.pathEnd) pathCnt <= pathCnt + DATA_W'(1);
      end
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R8
  AST_STEP_BOUND:  assert property (@(posedge clk) disable iff (!rstN) (state == ST_STEP) |-> (stepCnt < nSteps)); // R3
  AST_BUSY_HOLD:   assert property (@(posedge clk) disable iff (!rstN) (busy && start && state != ST_DONE) |=> busy); // R9
  AST_EMPTY_DONE:  assert property (@(posedge clk) disable iff (!rstN) (state == ST_IDLE && start && nSteps == '0) |=> done); // R10
endmodule

// File: rtl/mca_datapath.sv
module mca_datapath
  import mca_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  dp_ctl_t                  ctl,
  input  logic [DATA_W-1:0]        spot,
  input  logic [DATA_W-1:0]        strike,
  input  logic [DATA_W-1:0]        drift,
  input  logic [DATA_W-1:0]        vol,
  input  logic [DATA_W-1:0]        invSteps,
  input  logic [DATA_W-1:0]        invPaths,
  input  logic signed [DATA_W-1:0] eps,
  output logic [DATA_W-1:0]        meanAvg,
  output logic [DATA_W-1:0]        meanCall,
  output logic [DATA_W-1:0]        meanPut
);
  localparam int PROD_W = DATA_W + FACT_W;
  localparam int WIDE_W = ACC_W + DATA_W;
  localparam logic signed [FACT_W-1:0] ONE = FACT_W'(1 << FRAC_W);

  logic [DATA_W-1:0] price, priceNext, spotEff, sav, callPay, putPay;
  logic [ACC_W-1:0]  runSum, sumAvg, sumCall, sumPut;
  logic [DATA_W-1:0] outAvg, outCall, outPut;
  logic signed [FACT_W-1:0] factor;
  logic signed [PROD_W-1:0] prodShift;
  logic [ACC_W-1:0]  savWide;
  logic signed [DATA_W:0] diffCall, diffPut;

  function automatic logic [ACC_W-1:0] satAdd(input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ACC_W] ? '1 : s[ACC_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] scaleMean(input logic [ACC_W-1:0] sum, input logic [DATA_W-1:0] recip);
    logic [ACC_W-1:0] w;
    w = ACC_W'((WIDE_W'(sum) * WIDE_W'(recip)) >> DATA_W);
    return (w > ACC_W'(MAX_VAL)) ? MAX_VAL : w[DATA_W-1:0];
  endfunction

  // One compounding step: factor, product, clamp to the non-negative range
  assign factor = ONE + FACT_W'($signed(drift))
                + FACT_W'((64'($signed(vol)) * 64'(eps)) >>> FRAC_W);
  assign prodShift = (PROD_W'($signed({1'b0, price})) * PROD_W'(factor)) >>> FRAC_W;

  always_comb begin
    if (prodShift < 0)                            priceNext = '0;
    else if (prodShift > $signed(PROD_W'(MAX_VAL))) priceNext = MAX_VAL;
    else                                          priceNext = prodShift[DATA_W-1:0];
  end

  assign spotEff = spot[DATA_W-1] ? '0 : spot;

  // Path average and payoffs
  assign savWide  = ACC_W'((WIDE_W'(runSum) * WIDE_W'(invSteps)) >> DATA_W);
  assign sav      = (savWide > ACC_W'(MAX_VAL)) ? MAX_VAL : savWide[DATA_W-1:0];
  assign diffCall = $signed({1'b0, sav}) - $signed({strike[DATA_W-1], strike});
  assign diffPut  = -diffCall;

  always_comb begin
    if (diffCall <= 0)                             callPay = '0;
    else if (diffCall > $signed({1'b0, MAX_VAL}))  callPay = MAX_VAL;
    else                                           callPay = diffCall[DATA_W-1:0];
    if (diffPut <= 0)                              putPay = '0;
    else if (diffPut > $signed({1'b0, MAX_VAL}))   putPay = MAX_VAL;
    else                                           putPay = diffPut[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      price   <= '0;
      runSum  <= '0;
      sumAvg  <= '0;
      sumCall <= '0;
      sumPut  <= '0;
      outAvg  <= '0;
      outCall <= '0;
      outPut  <= '0;
    end else begin
      if (ctl.load) begin
        price   <= spotEff;
        runSum  <= '0;
        sumAvg  <= '0;
        sumCall <= '0;
        sumPut  <= '0;
      end
      if (ctl.step) begin
        price  <= priceNext;
        runSum <= satAdd(runSum, ACC_W'(priceNext));
      end
      if (ctl.pathEnd) begin
        sumAvg  <= satAdd(sumAvg, ACC_W'(sav));
        sumCall <= satAdd(sumCall, ACC_W'(callPay));
        sumPut  <= satAdd(sumPut, ACC_W'(putPay));
        price   <= spotEff;
        runSum  <= '0;
      end
      if (ctl.finish) begin
        outAvg  <= scaleMean(sumAvg, invPaths);
        outCall <= scaleMean(sumCall, invPaths);
        outPut  <= scaleMean(sumPut, invPaths);
      end
      if (ctl.zeroOut) begin
        outAvg  <= '0;
        outCall <= '0;
        outPut  <= '0;
      end
    end
  end

  assign meanAvg  = outAvg;
  assign meanCall = outCall;
  assign meanPut  = outPut;

  AST_PRICE_NONNEG: assert property (@(posedge clk) disable iff (!rstN) !price[DATA_W-1]); // R4
  AST_PAYOFF_EXCL:  assert property (@(posedge clk) disable iff (!rstN) ctl.pathEnd |-> (callPay == '0 || putPay == '0)); // R6
  AST_SUM_MONO:     assert property (@(posedge clk) disable iff (!rstN) ctl.pathEnd |=> (sumCall >= $past(sumCall) && sumPut >= $past(sumPut))); // R7
  AST_OUT_HOLD:     assert property (@(posedge clk) disable iff (!rstN) (!ctl.finish && !ctl.zeroOut) |=> ($stable(outAvg) && $stable(outCall) && $stable(outPut))); // R11
endmodule

// File: rtl/mc_asian_engine.sv
module mc_asian_engine
  import mca_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] meanAvg,
  output logic [DATA_W-1:0] meanCall,
  output logic [DATA_W-1:0] meanPut
);
  cfg_t                     cfgQ;
  dp_ctl_t                  ctl;
  logic signed [DATA_W-1:0] eps;

  mca_cfg u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .busy(busy), .cfgQ(cfgQ)
  );

  mca_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .nSteps(cfgQ.nSteps),
    .nPaths(cfgQ.nPaths), .ctl(ctl), .busy(busy), .done(done)
  );

  mca_gauss u_gauss (
    .clk(clk), .rstN(rstN), .reload(ctl.load), .advance(ctl.step),
    .seeds(cfgQ.seeds), .eps(eps)
  );

  mca_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .spot(cfgQ.spot), .strike(cfgQ.strike),
    .drift(cfgQ.drift), .vol(cfgQ.vol), .invSteps(cfgQ.invSteps),
    .invPaths(cfgQ.invPaths), .eps(eps), .meanAvg(meanAvg),
    .meanCall(meanCall), .meanPut(meanPut)
  );
endmodule

// File: tb/mc_asian_engine_bench.sv
module mc_asian_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [31:0] meanAvg, meanCall, meanPut;

  int nChecks = 0;
  int nFail   = 0;

  logic [31:0] tSpot, tStrike, tDrift, tVol, tSteps, tPaths, tInvS, tInvP;
  logic [15:0] tSeed [12];
  logic [31:0] eA, eC, eP;

  always #4 clk = ~clk;

  mc_asian_engine u_mc_asian_engine (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .start(start), .busy(busy), .done(done), .meanAvg(meanAvg),
    .meanCall(meanCall), .meanPut(meanPut)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic loadAll();
    wr(5'd0, tSpot);  wr(5'd1, tStrike); wr(5'd2, tDrift); wr(5'd3, tVol);
    wr(5'd4, tSteps); wr(5'd5, tPaths);  wr(5'd6, tInvS);  wr(5'd7, tInvP);
    for (int i = 0; i < 12; i++) wr(5'(8 + i), {16'h0, tSeed[i]});
  endtask

  function automatic logic [31:0] meanOf(input logic [63:0] s, input logic [31:0] r);
    logic [95:0] w;
    w = ({32'h0, s} * {64'h0, r}) >> 32;
    return (w > 96'h7FFF_FFFF) ? 32'h7FFF_FFFF : w[31:0];
  endfunction

  // Golden model built from the stated arithmetic
  task automatic model();
    logic [15:0] ln [12];
    logic [63:0] sA, sC, sP, rs;
    logic [31:0] pr, acc, sav, cpay, ppay;
    logic signed [31:0] eps;
    logic signed [63:0] vp, fct;
    logic signed [95:0] pa, pb, pw;
    logic [95:0] w;
    sA = 0; sC = 0; sP = 0;
    for (int i = 0; i < 12; i++) ln[i] = (tSeed[i] == 16'h0) ? 16'h1 : tSeed[i];
    if (tSteps == 0 || tPaths == 0) begin
      eA = 0; eC = 0; eP = 0;
      return;
    end
    for (int p = 0; p < int'(tPaths); p++) begin
      pr = tSpot[31] ? 32'h0 : tSpot;
      rs = 0;
      for (int n = 0; n < int'(tSteps); n++) begin
        acc = 0;
        for (int i = 0; i < 12; i++) begin
          acc = acc + {16'h0, ln[i]};
          ln[i] = {ln[i][14:0], ^(ln[i] & 16'hB400)};
        end
        eps = $signed(acc - 32'h0006_0000);
        vp  = $signed(tVol) * eps;
        fct = 64'sh10000 + $signed(tDrift) + (vp >>> 16);
        pa  = $signed({64'h0, pr});
        pb  = fct;
        pw  = (pa * pb) >>> 16;
        if (pw < 0) pr = 32'h0;
        else if (pw > 96'sh7FFF_FFFF) pr = 32'h7FFF_FFFF;
        else pr = pw[31:0];
        rs = rs + {32'h0, pr};
      end
      w    = ({32'h0, rs} * {64'h0, tInvS}) >> 32;
      sav  = (w > 96'h7FFF_FFFF) ? 32'h7FFF_FFFF : w[31:0];
      cpay = ($signed(sav) > $signed(tStrike)) ? sav - tStrike : 32'h0;
      ppay = ($signed(tStrike) > $signed(sav)) ? tStrike - sav : 32'h0;
      sA = sA + {32'h0, sav};
      sC = sC + {32'h0, cpay};
      sP = sP + {32'h0, ppay};
    end
    eA = meanOf(sA, tInvP);
    eC = meanOf(sC, tInvP);
    eP = meanOf(sP, tInvP);
  endtask

  // Pulse start, count edges after the sampling edge until done is seen
  task automatic runWait(output int edges, input bit meddle);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    if (meddle) chk("R8", "busy after start", {31'h0, busy}, 32'h1);
    while (!done) begin
      @(negedge clk);
      edges++;
      if (meddle && edges == 4) begin
        start = 1'b1; cfgWe = 1'b1; cfgAddr = 5'd1; cfgData = 32'h0001_0000;
      end
      if (meddle && edges == 5) begin
        start = 1'b0; cfgWe = 1'b0;
      end
      if (edges > 5000) begin
        chk("R8", "done timeout", 32'h0, 32'h1);
        return;
      end
    end
  endtask

  task automatic checkOuts(input string req);
    chk(req, "meanAvg", meanAvg, eA);
    chk(req, "meanCall", meanCall, eC);
    chk(req, "meanPut", meanPut, eP);
  endtask

  task automatic setDefaults();
    tSpot = 32'h0064_0000; tStrike = 32'h0065_0000; tDrift = 32'h0000_0148; tVol = 32'h0;
    tSteps = 8; tPaths = 3; tInvS = 32'h2000_0000; tInvP = 32'h5555_5555;
    for (int i = 0; i < 12; i++) tSeed[i] = 16'h1000 + 16'(i * 16'h0357) + 16'h1;
  endtask

  task automatic testReset();
    chk("R2", "busy", {31'h0, busy}, 32'h0);
    chk("R2", "done", {31'h0, done}, 32'h0);
    chk("R2", "meanAvg", meanAvg, 32'h0);
    chk("R2", "meanCall", meanCall, 32'h0);
    chk("R2", "meanPut", meanPut, 32'h0);
  endtask

  task automatic testDeterministic();
    int e;
    setDefaults();
    loadAll();
    model();
    runWait(e, 1'b1);
    chk("R8", "latency", 32'(e), 32'(3 * 9 + 1));
    checkOuts("R4 R5 R7");
    @(negedge clk);
    chk("R8", "done single cycle", {31'h0, done}, 32'h0);
    tStrike = 32'h006E_0000;
    wr(5'd1, tStrike);
    model();
    runWait(e, 1'b0);
    checkOuts("R6 put side");
  endtask

  task automatic testEqualStrike();
    int e;
    setDefaults();
    tDrift = 0; tSteps = 4; tPaths = 2; tInvS = 32'h4000_0000; tInvP = 32'h8000_0000;
    tStrike = tSpot;
    loadAll();
    runWait(e, 1'b0);
    chk("R6", "equal strike avg", meanAvg, tSpot);
    chk("R6", "equal strike call", meanCall, 32'h0);
    chk("R6", "equal strike put", meanPut, 32'h0);
  endtask

  task automatic testClamp();
    int e;
    setDefaults();
    tSpot = 32'h03E8_0000; tStrike = 0; tDrift = 32'h0001_0000; tSteps = 24; tPaths = 1;
    tInvS = 32'h0AAA_AAAA; tInvP = 32'hFFFF_FFFF;
    loadAll();
    model();
    runWait(e, 1'b0);
    checkOuts("R4 clamp");
  endtask

  task automatic testRandom();
    int e;
    logic [31:0] a0, c0, p0;
    setDefaults();
    tVol = 32'h0000_3333; tDrift = 32'h20; tStrike = 32'h0064_0000;
    tSteps = 16; tPaths = 20; tInvS = 32'h1000_0000; tInvP = 32'h0CCC_CCCC;
    loadAll();
    model();
    runWait(e, 1'b0);
    checkOuts("R3 R6");
    a0 = meanAvg; c0 = meanCall; p0 = meanPut;
    runWait(e, 1'b0);
    chk("R12", "repeat avg", meanAvg, a0);
    chk("R12", "repeat call", meanCall, c0);
    chk("R12", "repeat put", meanPut, p0);
    tSeed[0] = 16'h0;
    wr(5'd8, 32'h0);
    model();
    runWait(e, 1'b0);
    a0 = meanAvg;
    chk("R3", "zero seed model", meanAvg, eA);
    tSeed[0] = 16'h1;
    wr(5'd8, 32'h1);
    runWait(e, 1'b0);
    chk("R3", "zero seed equals seed 1", meanAvg, a0);
  endtask

  task automatic testBusy();
    int e;
    setDefaults();
    loadAll();
    model();
    runWait(e, 1'b1);
    chk("R9", "latency with start while busy", 32'(e), 32'(3 * 9 + 1));
    checkOuts("R9");
    runWait(e, 1'b0);
    checkOuts("R1 write while busy dropped");
  endtask

  task automatic testZero();
    int e;
    setDefaults();
    tSteps = 0;
    loadAll();
    runWait(e, 1'b0);
    chk("R10", "zero steps latency", 32'(e), 32'h0);
    chk("R10", "zero steps avg", meanAvg, 32'h0);
    chk("R10", "zero steps call", meanCall, 32'h0);
    chk("R10", "zero steps put", meanPut, 32'h0);
    tSteps = 8; tPaths = 0;
    wr(5'd4, tSteps); wr(5'd5, tPaths);
    runWait(e, 1'b0);
    chk("R10", "zero paths latency", 32'(e), 32'h0);
    chk("R10", "zero paths avg", meanAvg, 32'h0);
  endtask

  task automatic testHold();
    int e;
    setDefaults();
    loadAll();
    model();
    runWait(e, 1'b0);
    repeat (20) @(negedge clk);
    chk("R11", "hold busy", {31'h0, busy}, 32'h0);
    chk("R11", "hold done", {31'h0, done}, 32'h0);
    checkOuts("R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDeterministic();
    testEqualStrike();
    testClamp();
    testRandom();
    testBusy();
    testZero();
    testHold();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule